// File: doc/BRIEF.md
# Event Counter Performance Monitor

This block keeps four 32-bit up-counters that tally processor events. Each cycle the processor presents a 128-bit vector of single-cycle event pulses, a privilege bit (supervisor or user) and a mark bit. Every counter has two local control registers:

- **Control A** picks one of the 128 event lines and sets the conditions under which the counter is held.
- **Control B** only stores threshold fields.

A single global control register can hold every counter, enable the interrupt, and arrange for all counting to stop as soon as any counter reaches its overflow condition.

Software reaches the registers through a simple port that takes a 10-bit register number. Writes take effect at the clock edge; reads are combinational. Supervisor numbers are readable and writable. A second set of numbers reads the same registers but ignores writes.

For sampling, software presets a counter to 0x80000000 minus the wanted event count and sets that counter's condition enable. When the counter's most significant bit turns on, the level interrupt is raised, provided the global interrupt enable is set. It stays raised until software rewrites the counter or clears the enable.

Top module: `pmon_top`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Supervisor register numbers are as follows, with all other bits reading zero:

  | Register | Numbers | Stored bits |
  |---|---|---|
  | counter i | 0x010+i | all 32 bits |
  | control A i | 0x090+i | 31:26 and 22:16 |
  | control B i | 0x110+i | 10:8 and 5:0 |
  | global control | 0x190 | 31:29 |

- R3: Numbers 0x000+i, 0x080+i, 0x100+i and 0x180 read the same registers as their supervisor counterparts. Any number that maps to no register reads zero.
- R4: A write is ignored when it targets a read-only alias number, or when `priv_sup` is 0 during the write.
- R5: A counter adds one on each clock edge at which the event line chosen by its control A bits 22:16 is high and the counter is not held.
- R6: Control A bits hold the counter as follows:

  | Bit | Holds the counter |
  |---|---|
  | 31 | always |
  | 30 | while `priv_sup` is 1 |
  | 29 | while `priv_sup` is 0 |
  | 28 | while `mark` is 1 |
  | 27 | while `mark` is 0 |

- R7: Global control bit 31 holds all counters.
- R8: When a supervisor write to a counter and an increment of that counter fall on the same edge, the written value is kept.
- R9: A counter's condition is the AND of its control A bit 26 and its own bit 31. `irq` is high while global bit 30 is set and any condition is present. It falls once the counter is rewritten below 0x80000000.
- R10: While global bit 29 is set, any present condition holds every counter in that same cycle. The condition also sets global bit 31 at the next edge, and that bit stays set until software clears it.
- R11: When global bit 29 is clear, a counter keeps counting past 0x80000000. It wraps from 0xFFFFFFFF to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_num | input | 10 | Register number for read and write |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| evt_in | input | 128 | Per-cycle event pulses |
| priv_sup | input | 1 | 1 = supervisor state, 0 = user state |
| mark | input | 1 | Mark state of the running process |
| irq | output | 1 | Level interrupt |

## Verification
A wrong hold qualification or event selection shows up as a counter value that drifts from the expected tally. The error is visible on the next read of that counter, one edge after the offending event cycle. A missing or late automatic freeze has two symptoms:

- a neighbouring counter gains extra counts past the moment of overflow;
- global bit 31 reads clear one edge after the condition appeared.

A wrong condition term appears on `irq` in the same cycle the counter crosses 0x80000000, or the cycle after it is rewritten.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
  localparam int NUM_CTR = 4;
  localparam int CNT_W   = 32;
  localparam int NUM_EVT = 128;
  localparam int SEL_W   = $clog2(NUM_EVT);

  // field positions the behaviour depends on
  localparam int A_HOLD    = 31;
  localparam int A_HOLDSUP = 30;
  localparam int A_HOLDUSR = 29;
  localparam int A_HOLDM1  = 28;
  localparam int A_HOLDM0  = 27;
  localparam int A_CONDEN  = 26;
  localparam int A_SEL_LO  = 16;
  localparam int G_FRZ     = 31;
  localparam int G_IEN     = 30;
  localparam int G_FOC     = 29;

  localparam logic [31:0] A_MASK = 32'hFC7F_0000;
  localparam logic [31:0] B_MASK = 32'h0000_073F;
  localparam logic [31:0] G_MASK = 32'hE000_0000;

  typedef enum logic [1:0] {RC_CNT = 2'd0, RC_CTLA = 2'd1, RC_CTLB = 2'd2, RC_GLB = 2'd3} regclass_e;

  typedef struct packed {
    logic      hit;
    logic      sup;
    regclass_e cls;
    logic [1:0] idx;
  } regsel_t;

  // register number decode: class in [8:7], supervisor copy flag in [4], index in [1:0]
  function automatic regsel_t f_decode(input logic [9:0] n);
    regsel_t s;
    s.cls = regclass_e'(n[8:7]);
    s.sup = n[4];
    s.idx = n[1:0];
    s.hit = !n[9] && (n[6:5] == 2'b00) && (n[3:2] == 2'b00) &&
            ((n[8:7] != 2'd3) || (n[1:0] == 2'b00));
    return s;
  endfunction

  // hold bits are A[31:27]; returns 1 when the local conditions let the counter run
  function automatic logic f_runs(input logic [4:0] hold, input logic sup, input logic mk);
    return !(hold[4] || (sup && hold[3]) || (!sup && hold[2]) ||
             (mk && hold[1]) || (!mk && hold[0]));
  endfunction
endpackage

// File: rtl/pmon_slice.sv
module pmon_slice
  import pmon_pkg::*;
#(
  parameter int CW   = CNT_W,
  parameter int NEVT = NUM_EVT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_cnt,
  input  logic            wr_ctla,
  input  logic            wr_ctlb,
  input  logic [31:0]     wdata,
  input  logic [NEVT-1:0] evt,
  input  logic            sup,
  input  logic            mk,
  input  logic            stop_all,
  output logic [CW-1:0]   cnt_q,
  output logic [31:0]     ctla_q,
  output logic [31:0]     ctlb_q,
  output logic            cond_o
);
  localparam int SW = $clog2(NEVT);

  logic [SW-1:0] sel;
  logic          step;

  assign sel    = ctla_q[A_SEL_LO +: SW];
  assign step   = evt[sel] && !stop_all && f_runs(ctla_q[A_HOLD:A_HOLDM0], sup, mk);
  assign cond_o = ctla_q[A_CONDEN] && cnt_q[CW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ctla_q <= '0;
      ctlb_q <= '0;
    end else begin
      if (wr_cnt)       cnt_q <= wdata[CW-1:0];
      else if (step)    cnt_q <= cnt_q + 1'b1;
      if (wr_ctla)      ctla_q <= wdata & A_MASK;
      if (wr_ctlb)      ctlb_q <= wdata & B_MASK;
    end
  end
endmodule

// File: rtl/pmon_glb.sv
module pmon_glb
  import pmon_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [31:0] wdata,
  input  logic        any_cond,
  output logic [31:0] gctl_q,
  output logic        stop_all,
  output logic        irq
);
  logic trip;

  assign trip     = any_cond && gctl_q[G_FOC];
  assign stop_all = gctl_q[G_FRZ] || trip;
  assign irq      = gctl_q[G_IEN] && any_cond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    gctl_q <= '0;
    else if (wr)   gctl_q <= wdata & G_MASK;
    else if (trip) gctl_q[G_FRZ] <= 1'b1;
  end
endmodule

// File: rtl/pmon_top.sv
module pmon_top
  import pmon_pkg::*;
#(
  parameter int N_CTR = NUM_CTR,
  parameter int CW    = CNT_W,
  parameter int NEVT  = NUM_EVT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [9:0]      reg_num,
  input  logic            reg_wr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic [NEVT-1:0] evt_in,
  input  logic            priv_sup,
  input  logic            mark,
  output logic            irq
);
  regsel_t                     rs;
  logic                        wr_ok;
  logic [N_CTR-1:0]            wr_cnt, wr_ctla, wr_ctlb;
  logic                        wr_glb;
  logic [N_CTR-1:0][CW-1:0]    cnt;
  logic [N_CTR-1:0][31:0]      ctla, ctlb;
  logic [N_CTR-1:0]            cond_vec;
  logic [31:0]                 gctl;
  logic                        stop_all;

  assign rs     = f_decode(reg_num);
  assign wr_ok  = reg_wr && priv_sup && rs.hit && rs.sup;
  assign wr_glb = wr_ok && (rs.cls == RC_GLB);

  for (genvar i = 0; i < N_CTR; i++) begin : g_slice
    assign wr_cnt[i]  = wr_ok && (rs.cls == RC_CNT)  && (rs.idx == i[1:0]);
    assign wr_ctla[i] = wr_ok && (rs.cls == RC_CTLA) && (rs.idx == i[1:0]);
    assign wr_ctlb[i] = wr_ok && (rs.cls == RC_CTLB) && (rs.idx == i[1:0]);

    pmon_slice #(.CW(CW), .NEVT(NEVT)) u_slice (
      .clk(clk), .rst_n(rst_n),
      .wr_cnt(wr_cnt[i]), .wr_ctla(wr_ctla[i]), .wr_ctlb(wr_ctlb[i]),
      .wdata(reg_wdata), .evt(evt_in), .sup(priv_sup), .mk(mark),
      .stop_all(stop_all),
      .cnt_q(cnt[i]), .ctla_q(ctla[i]), .ctlb_q(ctlb[i]), .cond_o(cond_vec[i])
    );
  end

  pmon_glb u_glb (
    .clk(clk), .rst_n(rst_n), .wr(wr_glb), .wdata(reg_wdata),
    .any_cond(|cond_vec), .gctl_q(gctl), .stop_all(stop_all), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (rs.hit && (int'(rs.idx) < N_CTR || rs.cls == RC_GLB)) begin
      unique case (rs.cls)
        RC_CNT:  reg_rdata = 32'(cnt[rs.idx]);
        RC_CTLA: reg_rdata = ctla[rs.idx];
        RC_CTLB: reg_rdata = ctlb[rs.idx];
        RC_GLB:  reg_rdata = gctl;
      endcase
    end
  end
endmodule

// File: rtl/pmon_checks.sv
module pmon_checks
  import pmon_pkg::*;
#(
  parameter int N_CTR = NUM_CTR,
  parameter int CW    = CNT_W
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [9:0]               reg_num,
  input logic                     reg_wr,
  input logic                     priv_sup,
  input logic                     irq,
  input logic [N_CTR-1:0][CW-1:0] cnt,
  input logic [N_CTR-1:0][31:0]   ctla,
  input logic [N_CTR-1:0][31:0]   ctlb,
  input logic [N_CTR-1:0]         cond_vec,
  input logic [N_CTR-1:0]         wr_cnt,
  input logic [31:0]              gctl
);
  logic glb_wr_seen;
  assign glb_wr_seen = reg_wr && priv_sup && (reg_num == 10'h190);

  for (genvar i = 0; i < N_CTR; i++) begin : g_ctr
    assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_cnt[i] |=> (cnt[i] == $past(cnt[i])) || (cnt[i] == $past(cnt[i]) + 1'b1));
    assert_global_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (gctl[G_FRZ] && !wr_cnt[i]) |=> $stable(cnt[i]));
    assert_trip_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((|cond_vec) && gctl[G_FOC] && !wr_cnt[i]) |=> $stable(cnt[i]));
  end

  assert_auto_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((|cond_vec) && gctl[G_FOC] && !glb_wr_seen) |=> gctl[G_FRZ]);

  assert_ignored_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (!priv_sup || !reg_num[4])) |=> ($stable(ctla) && $stable(ctlb)));

  assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (gctl[G_IEN] && (|cond_vec)));
endmodule

bind pmon_top pmon_checks #(.N_CTR(N_CTR), .CW(CW)) u_checks (
  .clk(clk), .rst_n(rst_n), .reg_num(reg_num), .reg_wr(reg_wr),
  .priv_sup(priv_sup), .irq(irq), .cnt(cnt), .ctla(ctla), .ctlb(ctlb),
  .cond_vec(cond_vec), .wr_cnt(wr_cnt), .gctl(gctl)
);

// File: tb/pmon_top_bench.sv
`timescale 1ns/1ps
module pmon_top_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [9:0]   reg_num = '0;
  logic         reg_wr = 1'b0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic [127:0] evt_in = '0;
  logic         priv_sup = 1'b1;
  logic         mark = 1'b0;
  logic         irq;
  int           n_chk = 0;
  int           n_bad = 0;
  bit           done = 1'b0;

  always #2.5 clk = ~clk;

  pmon_top u_pmon_top (
    .clk(clk), .rst_n(rst_n), .reg_num(reg_num), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in),
    .priv_sup(priv_sup), .mark(mark), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] n, input logic [31:0] d);
    logic keep;
    @(negedge clk);
    keep = priv_sup;
    priv_sup = 1'b1; reg_num = n; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; priv_sup = keep;
  endtask

  task automatic rd_chk(input string req, input logic [9:0] n, input logic [31:0] exp);
    reg_num = n;
    #0.5;
    chk(req, reg_rdata, exp);
  endtask

  task automatic burst(input int bitn, input int k);
    @(negedge clk);
    evt_in = '0; evt_in[bitn] = 1'b1;
    repeat (k) @(negedge clk);
    evt_in = '0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      rd_chk("R1", 10'h010 + 10'(i), 0);
      rd_chk("R1", 10'h090 + 10'(i), 0);
      rd_chk("R1", 10'h110 + 10'(i), 0);
    end
    rd_chk("R1", 10'h190, 0);
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_regmap;
    wr(10'h091, 32'hFFFF_FFFF);
    wr(10'h112, 32'hFFFF_FFFF);
    wr(10'h013, 32'hDEAD_BEEF);
    wr(10'h190, 32'h9FFF_FFFF);
    rd_chk("R2 ctlA", 10'h091, 32'hFC7F_0000);
    rd_chk("R2 ctlB", 10'h112, 32'h0000_073F);
    rd_chk("R2 cnt",  10'h013, 32'hDEAD_BEEF);
    rd_chk("R2 glb",  10'h190, 32'h8000_0000);
    rd_chk("R3 alias ctlA", 10'h081, 32'hFC7F_0000);
    rd_chk("R3 alias ctlB", 10'h102, 32'h0000_073F);
    rd_chk("R3 alias cnt",  10'h003, 32'hDEAD_BEEF);
    rd_chk("R3 alias glb",  10'h180, 32'h8000_0000);
    rd_chk("R3 unmapped",   10'h014, 0);
    rd_chk("R3 unmapped",   10'h191, 0);
    rd_chk("R3 unmapped",   10'h213, 0);
    wr(10'h081, 32'h0);
    wr(10'h102, 32'h0);
    rd_chk("R4 alias write", 10'h091, 32'hFC7F_0000);
    rd_chk("R4 alias write", 10'h112, 32'h0000_073F);
    @(negedge clk);
    priv_sup = 1'b0; reg_num = 10'h091; reg_wdata = 0; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; priv_sup = 1'b1;
    rd_chk("R4 user write", 10'h091, 32'hFC7F_0000);
    wr(10'h091, 0); wr(10'h112, 0); wr(10'h013, 0); wr(10'h190, 0);
  endtask

  task automatic t_count;
    wr(10'h090, 32'h0005_0000);
    wr(10'h091, 32'h007F_0000);
    wr(10'h092, 32'h0000_0000);
    wr(10'h093, 32'h0005_0000);
    for (int i = 0; i < 4; i++) wr(10'h010 + 10'(i), 0);
    @(negedge clk);
    evt_in = '0; evt_in[5] = 1'b1; evt_in[127] = 1'b1;
    repeat (6) @(negedge clk);
    evt_in = '0; evt_in[0] = 1'b1;
    repeat (2) @(negedge clk);
    evt_in = '0;
    rd_chk("R5 sel5",   10'h010, 6);
    rd_chk("R5 sel127", 10'h011, 6);
    rd_chk("R5 sel0",   10'h012, 2);
    rd_chk("R5 shared", 10'h013, 6);
    wr(10'h011, 32'hFFFF_FFFF);
    burst(127, 2);
    rd_chk("R11 wrap", 10'h011, 1);
  endtask

  task automatic t_qualify;
    wr(10'h010, 0);
    wr(10'h090, 32'h400A_0000);
    priv_sup = 1'b1; burst(10, 4);
    rd_chk("R6 hold sup", 10'h010, 0);
    priv_sup = 1'b0; burst(10, 3); priv_sup = 1'b1;
    rd_chk("R6 run user", 10'h010, 3);
    wr(10'h090, 32'h200A_0000);
    priv_sup = 1'b0; burst(10, 2); priv_sup = 1'b1;
    rd_chk("R6 hold user", 10'h010, 3);
    burst(10, 2);
    rd_chk("R6 run sup", 10'h010, 5);
    wr(10'h090, 32'h100A_0000);
    mark = 1'b1; burst(10, 2);
    rd_chk("R6 hold mark1", 10'h010, 5);
    mark = 1'b0; burst(10, 2);
    rd_chk("R6 run mark0", 10'h010, 7);
    wr(10'h090, 32'h080A_0000);
    burst(10, 2);
    rd_chk("R6 hold mark0", 10'h010, 7);
    mark = 1'b1; burst(10, 1); mark = 1'b0;
    rd_chk("R6 run mark1", 10'h010, 8);
    wr(10'h090, 32'h800A_0000);
    burst(10, 3);
    rd_chk("R6 hold always", 10'h010, 8);
    wr(10'h090, 32'h000A_0000);
    wr(10'h190, 32'h8000_0000);
    burst(10, 3);
    rd_chk("R7 global hold", 10'h010, 8);
    wr(10'h190, 0);
    burst(10, 1);
    rd_chk("R7 released", 10'h010, 9);
  endtask

  task automatic t_priority;
    wr(10'h090, 32'h0005_0000);
    @(negedge clk);
    priv_sup = 1'b1; reg_num = 10'h010; reg_wdata = 32'h0000_1234; reg_wr = 1'b1;
    evt_in = '0; evt_in[5] = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    rd_chk("R8 write wins", 10'h010, 32'h0000_1234);
    @(negedge clk);
    evt_in = '0;
    rd_chk("R8 then counts", 10'h010, 32'h0000_1235);
  endtask

  task automatic t_overflow_freeze;
    wr(10'h092, 32'h0409_0000);
    wr(10'h093, 32'h0009_0000);
    wr(10'h012, 32'h7FFF_FFFD);
    wr(10'h013, 0);
    wr(10'h190, 32'h6000_0000);
    chk("R9 no irq yet", 32'(irq), 0);
    burst(9, 5);
    rd_chk("R10 trip cnt", 10'h012, 32'h8000_0000);
    rd_chk("R10 all held", 10'h013, 3);
    rd_chk("R10 frz set",  10'h190, 32'hE000_0000);
    chk("R9 irq high", 32'(irq), 1);
    wr(10'h012, 0);
    chk("R9 irq drops", 32'(irq), 0);
    burst(9, 2);
    rd_chk("R10 frz sticky", 10'h190, 32'hE000_0000);
    rd_chk("R10 still held", 10'h013, 3);
    wr(10'h190, 32'h6000_0000);
    burst(9, 2);
    rd_chk("R10 resumed", 10'h013, 5);
    rd_chk("R10 resumed", 10'h012, 2);
  endtask

  task automatic t_no_trip;
    wr(10'h190, 0);
    wr(10'h012, 32'h7FFF_FFFE);
    burst(9, 4);
    rd_chk("R11 past msb", 10'h012, 32'h8000_0002);
    rd_chk("R11 no frz",   10'h190, 0);
    chk("R9 ien off", 32'(irq), 0);
    wr(10'h190, 32'h4000_0000);
    chk("R9 ien on", 32'(irq), 1);
    wr(10'h092, 32'h0009_0000);
    chk("R9 cond off", 32'(irq), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_count();
    t_qualify();
    t_priority();
    t_overflow_freeze();
    t_no_trip();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule